// File: doc/BRIEF.md
# Disk Command Block Issuer

This block sends one command block to a disk attachment through the attachment's 16-bit command register. A request on `start` latches the command fields. The block then asks the attention sequencer for a command-request attention. Once the sequencer reports success, the block writes the command words one at a time. After each write it waits for the attachment to take the word out of the register. After the last word it waits for the attachment to drop its command-in-progress status. It then pulses `done` and holds a result code until the next request.

The first word is always built from the command code, the device number, the options and the block type. A read-data or write-data command always uses the four-word form. For these two commands the options are forced to 2, and the block count and the cylinder/head/sector address are packed into words 1 to 3. The cylinder is split across words 2 and 3. Any other command sends its argument words unchanged, as two words or as four. Two bounded waits cover the two status bits. One counts how often the register-full bit is seen set after a word. The other counts how often the in-progress bit is seen set after the last word.

The sequencer has six states: IDLE, ATTN, SEND, DRAIN, WAIT and FINISH. Its transitions are:
- IDLE to ATTN when `start` is high.
- ATTN to SEND when the attention succeeds.
- ATTN to FINISH when the attention fails.
- SEND to DRAIN on every word.
- DRAIN to SEND when the register is empty and words remain.
- DRAIN to WAIT when the register is empty after the last word.
- DRAIN to FINISH on the too-slow limit.
- WAIT to FINISH when in-progress clears, or on the completion limit.
- FINISH to IDLE always.

Top module: `cmd_block_issuer`

## Requirements
- R1: After reset, `busy`, `done`, `attn_req` and `cifr_we` are 0 and `err_code` is 0.
- R2: A `start` in IDLE raises `attn_req` on the next cycle. `attn_req` stays high until `attn_done`. A `start` while `busy` is high is ignored, and the words sent belong to the first request.
- R3: If `attn_done` arrives with `attn_ok`=0, no word is written. `done` follows with `err_code`=1 (attention timeout).
- R4: Word 0 is laid out as follows: bits 15:14 hold the type (00 = two words, 01 = four words); bits 13:8 hold the options; bits 7:5 hold the device; bits 4:0 hold the command code. `cifr_data[7:0]` carries the low byte of each word.
- R5: Code 1 (read data) and code 2 (write data) always send four words with options 2. Word 1 is the block count. Word 2 is {cyl[4:0], head[5:0], sector[4:0]}. Word 3 is cyl[9:5] in bits 4:0, with zeros above.
- R6: Any other code sends `arg1`, or `arg1` to `arg3`, as words 1 onward. The count is two words when `long_form`=0 and four words when `long_form`=1.
- R7: After each word the block checks `reg_full` once per cycle. The next word is written only after `reg_full` has been seen clear, so `cifr_we` is never high on two consecutive cycles.
- R8: If `reg_full` is seen set on FULL_TRIES consecutive checks after a word, the block stops sending and ends with `err_code`=2 (too slow). If the register drains after FULL_TRIES-1 set checks, the command continues.
- R9: After the last word drains, the block waits for `cmd_busy` to clear and then ends with `err_code`=0.
- R10: If `cmd_busy` is seen set on DONE_LIMIT consecutive checks, the block ends with `err_code`=3 (completion timeout).
- R11: `done` is a one-cycle pulse. `err_code` keeps its value from `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to issue a command (taken in IDLE) |
| cmd_code | input | 5 | Command code |
| dev_num | input | 3 | Device number |
| cmd_opts | input | 6 | Options field (not used for codes 1 and 2) |
| long_form | input | 1 | 1 = four-word block for generic codes |
| blk_count | input | 16 | Transfer length in 512-byte blocks (codes 1, 2) |
| cyl | input | 10 | Cylinder (codes 1, 2) |
| head | input | 6 | Head (codes 1, 2) |
| sector | input | 5 | Sector (codes 1, 2) |
| arg1 | input | 16 | Raw word 1 for generic codes |
| arg2 | input | 16 | Raw word 2 for generic codes |
| arg3 | input | 16 | Raw word 3 for generic codes |
| attn_req | output | 1 | Command-request attention wanted |
| attn_done | input | 1 | Attention sequencer finished |
| attn_ok | input | 1 | Attention succeeded (valid with attn_done) |
| cifr_we | output | 1 | Write strobe to the command register |
| cifr_data | output | 16 | Command word, low byte in bits 7:0 |
| reg_full | input | 1 | Command register still holds a word |
| cmd_busy | input | 1 | Attachment command in progress |
| busy | output | 1 | A command is being handled |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 attention timeout, 2 too slow, 3 completion timeout |

## Verification
A wrong word index or a wrong packing choice shows up as a bad `cifr_data` value on the write strobe. It is therefore visible a few cycles after `start`, on the first word that goes wrong. A check counter that is off by one moves the limit between success and an `err_code` of 2 or 3. Only a stall held just below or at the limit exposes this, and it shows at the `done` that ends that command. A sequencer that skips a drain or attention step shows up as back-to-back strobes, or as words written after a failed attention.

// File: rtl/cbi_pkg.sv
package cbi_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ATTN,
        S_SEND,
        S_DRAIN,
        S_WAIT,
        S_FINISH
    } cbi_state_e;

    localparam int WORD_W = 16;
    localparam int CODE_W = 5;
    localparam int DEV_W  = 3;
    localparam int OPT_W  = 6;
    localparam int CYL_W  = 10;
    localparam int HEAD_W = 6;
    localparam int SEC_W  = 5;
    localparam int MAX_WORDS = 4;
    localparam int IDX_W  = $clog2(MAX_WORDS);

    localparam logic [1:0] ERR_NONE  = 2'd0;
    localparam logic [1:0] ERR_ATTN  = 2'd1;
    localparam logic [1:0] ERR_SLOW  = 2'd2;
    localparam logic [1:0] ERR_STUCK = 2'd3;

    localparam logic [CODE_W-1:0] CODE_READ  = 5'd1;
    localparam logic [CODE_W-1:0] CODE_WRITE = 5'd2;
    localparam logic [OPT_W-1:0]  RW_OPTIONS = 6'd2;

    localparam logic [1:0] TYPE_SHORT = 2'b00;
    localparam logic [1:0] TYPE_LONG  = 2'b01;

endpackage

// File: rtl/cbi_word_pack.sv
module cbi_word_pack
    import cbi_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic [DEV_W-1:0]  dev,
    input  logic [OPT_W-1:0]  opts,
    input  logic              long_form,
    input  logic [WORD_W-1:0] blk_count,
    input  logic [CYL_W-1:0]  cyl,
    input  logic [HEAD_W-1:0] head,
    input  logic [SEC_W-1:0]  sector,
    input  logic [WORD_W-1:0] arg1,
    input  logic [WORD_W-1:0] arg2,
    input  logic [WORD_W-1:0] arg3,
    output logic [MAX_WORDS-1:0][WORD_W-1:0] words,
    output logic [IDX_W-1:0]  last_idx
);

    localparam int CYL_LO_W = WORD_W - HEAD_W - SEC_W;
    localparam int CYL_HI_W = CYL_W - CYL_LO_W;

    logic              is_rw;
    logic [1:0]        blk_type;
    logic [OPT_W-1:0]  eff_opts;
    logic [WORD_W-1:0] chs_word;
    logic [WORD_W-1:0] cyl_hi_word;

    always_comb begin
        is_rw       = (code == CODE_READ) || (code == CODE_WRITE);
        blk_type    = (is_rw || long_form) ? TYPE_LONG : TYPE_SHORT;
        eff_opts    = is_rw ? RW_OPTIONS : opts;
        chs_word    = {cyl[CYL_LO_W-1:0], head, sector};
        cyl_hi_word = {{(WORD_W-CYL_HI_W){1'b0}}, cyl[CYL_W-1:CYL_LO_W]};

        words[0] = {blk_type, eff_opts, dev, code};
        words[1] = is_rw ? blk_count   : arg1;
        words[2] = is_rw ? chs_word    : arg2;
        words[3] = is_rw ? cyl_hi_word : arg3;

        last_idx = (blk_type == TYPE_LONG) ? IDX_W'(MAX_WORDS-1) : IDX_W'(1);
    end

endmodule

// File: rtl/cbi_check_counter.sv
module cbi_check_counter #(
    parameter int LIMIT = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic hit
);

    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (step && cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit = step && (cnt == TOP);

    // R8 and R10: the caller leaves its wait state on hit, so the count never passes the limit
    assert_count_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        step && (cnt == TOP) |=> (cnt == '0) || (cnt == TOP));

endmodule

// File: rtl/cmd_block_issuer.sv
module cmd_block_issuer
    import cbi_pkg::*;
#(
    parameter int FULL_TRIES = 10000,
    parameter int DONE_LIMIT = 50000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [4:0]  cmd_code,
    input  logic [2:0]  dev_num,
    input  logic [5:0]  cmd_opts,
    input  logic        long_form,
    input  logic [15:0] blk_count,
    input  logic [9:0]  cyl,
    input  logic [5:0]  head,
    input  logic [4:0]  sector,
    input  logic [15:0] arg1,
    input  logic [15:0] arg2,
    input  logic [15:0] arg3,
    output logic        attn_req,
    input  logic        attn_done,
    input  logic        attn_ok,
    output logic        cifr_we,
    output logic [15:0] cifr_data,
    input  logic        reg_full,
    input  logic        cmd_busy,
    output logic        busy,
    output logic        done,
    output logic [1:0]  err_code
);

    cbi_state_e state, state_nx;

    logic [CODE_W-1:0] lat_code;
    logic [DEV_W-1:0]  lat_dev;
    logic [OPT_W-1:0]  lat_opts;
    logic              lat_long;
    logic [WORD_W-1:0] lat_blk;
    logic [CYL_W-1:0]  lat_cyl;
    logic [HEAD_W-1:0] lat_head;
    logic [SEC_W-1:0]  lat_sec;
    logic [WORD_W-1:0] lat_a1, lat_a2, lat_a3;

    logic [MAX_WORDS-1:0][WORD_W-1:0] words;
    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] idx;
    logic [1:0]       err_q;
    logic             slow_hit, stuck_hit;
    logic             accept;

    assign accept = (state == S_IDLE) && start;

    cbi_word_pack u_pack (
        .code      (lat_code),
        .dev       (lat_dev),
        .opts      (lat_opts),
        .long_form (lat_long),
        .blk_count (lat_blk),
        .cyl       (lat_cyl),
        .head      (lat_head),
        .sector    (lat_sec),
        .arg1      (lat_a1),
        .arg2      (lat_a2),
        .arg3      (lat_a3),
        .words     (words),
        .last_idx  (last_idx)
    );

    cbi_check_counter #(.LIMIT(FULL_TRIES)) u_full_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state != S_DRAIN),
        .step  ((state == S_DRAIN) && reg_full),
        .hit   (slow_hit)
    );

    cbi_check_counter #(.LIMIT(DONE_LIMIT)) u_done_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state != S_WAIT),
        .step  ((state == S_WAIT) && cmd_busy),
        .hit   (stuck_hit)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (start) state_nx = S_ATTN;
            S_ATTN:   if (attn_done) state_nx = attn_ok ? S_SEND : S_FINISH;
            S_SEND:   state_nx = S_DRAIN;
            S_DRAIN: begin
                if (!reg_full)     state_nx = (idx == last_idx) ? S_WAIT : S_SEND;
                else if (slow_hit) state_nx = S_FINISH;
            end
            S_WAIT:   if (!cmd_busy || stuck_hit) state_nx = S_FINISH;
            S_FINISH: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // latched command, word index, result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_code <= '0; lat_dev <= '0; lat_opts <= '0; lat_long <= 1'b0;
            lat_blk  <= '0; lat_cyl <= '0; lat_head <= '0; lat_sec  <= '0;
            lat_a1   <= '0; lat_a2  <= '0; lat_a3   <= '0;
            idx      <= '0;
            err_q    <= ERR_NONE;
        end else begin
            if (accept) begin
                lat_code <= cmd_code; lat_dev <= dev_num; lat_opts <= cmd_opts;
                lat_long <= long_form; lat_blk <= blk_count; lat_cyl <= cyl;
                lat_head <= head; lat_sec <= sector;
                lat_a1 <= arg1; lat_a2 <= arg2; lat_a3 <= arg3;
                idx    <= '0;
                err_q  <= ERR_NONE;
            end
            if (state == S_ATTN && attn_done && !attn_ok) err_q <= ERR_ATTN;
            if (state == S_DRAIN && !reg_full && idx != last_idx) idx <= idx + 1'b1;
            if (state == S_DRAIN && reg_full && slow_hit) err_q <= ERR_SLOW;
            if (state == S_WAIT && cmd_busy && stuck_hit) err_q <= ERR_STUCK;
        end
    end

    // outputs
    always_comb begin
        attn_req  = 1'b0;
        cifr_we   = 1'b0;
        done      = 1'b0;
        busy      = 1'b1;
        unique case (state)
            S_IDLE:   busy     = 1'b0;
            S_ATTN:   attn_req = 1'b1;
            S_SEND:   cifr_we  = 1'b1;
            S_DRAIN:  ;
            S_WAIT:   ;
            S_FINISH: done     = 1'b1;
            default:  busy     = 1'b0;
        endcase
        cifr_data = words[idx];
        err_code  = err_q;
    end

    assert_attn_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        attn_req && !attn_done |=> attn_req);

    assert_attn_fail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        attn_req && attn_done && !attn_ok |=> done && !cifr_we && (err_code == ERR_ATTN));

    assert_no_back_to_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cifr_we |=> !cifr_we);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    assert_err_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(err_code));

endmodule

// File: tb/sim_cmd_block_issuer.sv
module sim_cmd_block_issuer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  cmd_code = '0;
    logic [2:0]  dev_num = '0;
    logic [5:0]  cmd_opts = '0;
    logic        long_form = 1'b0;
    logic [15:0] blk_count = '0;
    logic [9:0]  cyl = '0;
    logic [5:0]  head = '0;
    logic [4:0]  sector = '0;
    logic [15:0] arg1 = '0, arg2 = '0, arg3 = '0;
    logic        attn_req, cifr_we, busy, done;
    logic        attn_done = 1'b0, attn_ok = 1'b0;
    logic [15:0] cifr_data;
    logic        reg_full = 1'b0, cmd_busy = 1'b0;
    logic [1:0]  err_code;

    localparam int DLIM = 300;

    cmd_block_issuer #(.FULL_TRIES(10000), .DONE_LIMIT(DLIM)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_code(cmd_code),
        .dev_num(dev_num), .cmd_opts(cmd_opts), .long_form(long_form),
        .blk_count(blk_count), .cyl(cyl), .head(head), .sector(sector),
        .arg1(arg1), .arg2(arg2), .arg3(arg3),
        .attn_req(attn_req), .attn_done(attn_done), .attn_ok(attn_ok),
        .cifr_we(cifr_we), .cifr_data(cifr_data), .reg_full(reg_full),
        .cmd_busy(cmd_busy), .busy(busy), .done(done), .err_code(err_code)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // attachment model configuration
    int hold_cfg = 1;
    bit never_drain = 1'b0;
    int busy_cfg = 3;
    int attn_lat = 1;
    bit attn_ok_cfg = 1'b1;
    int hcnt = 0, bcnt = 0, acnt = 0;

    // command under test (bench copy)
    logic [4:0]  c_code;
    logic [2:0]  c_dev;
    logic [5:0]  c_opts;
    logic        c_long;
    logic [15:0] c_blk, c_a1, c_a2, c_a3;
    logic [9:0]  c_cyl;
    logic [5:0]  c_head;
    logic [4:0]  c_sec;

    logic [15:0] got [4];
    int nw = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            reg_full <= 1'b0; cmd_busy <= 1'b0; attn_done <= 1'b0; acnt <= 0;
        end else begin
            if (cifr_we) begin
                reg_full <= (hold_cfg != 0) || never_drain;
                hcnt     <= hold_cfg - 1;
                cmd_busy <= (busy_cfg != 0);
                bcnt     <= busy_cfg;
            end else begin
                if (reg_full && !never_drain) begin
                    if (hcnt <= 0) reg_full <= 1'b0;
                    else           hcnt <= hcnt - 1;
                end
                if (cmd_busy && !reg_full) begin
                    if (bcnt <= 1) cmd_busy <= 1'b0;
                    else           bcnt <= bcnt - 1;
                end
            end
            if (attn_done) attn_done <= 1'b0;
            else if (attn_req) begin
                if (acnt >= attn_lat) begin
                    attn_done <= 1'b1; attn_ok <= attn_ok_cfg; acnt <= 0;
                end else acnt <= acnt + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && cifr_we) begin
            if (nw < 4) got[nw] = cifr_data;
            nw = nw + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit is_rw();
        return (c_code == 5'd1) || (c_code == 5'd2);
    endfunction

    function automatic int exp_n();
        return (is_rw() || c_long) ? 4 : 2;
    endfunction

    function automatic logic [15:0] exp_word(input int i);
        logic [1:0] t;
        t = (is_rw() || c_long) ? 2'b01 : 2'b00;
        case (i)
            0: return {t, is_rw() ? 6'd2 : c_opts, c_dev, c_code};
            1: return is_rw() ? c_blk : c_a1;
            2: return is_rw() ? {c_cyl[4:0], c_head, c_sec} : c_a2;
            default: return is_rw() ? {11'd0, c_cyl[9:5]} : c_a3;
        endcase
    endfunction

    task automatic set_cmd(input logic [4:0] code, input logic [2:0] dv,
                           input logic [5:0] op, input logic lf,
                           input logic [15:0] bk, input logic [9:0] cy,
                           input logic [5:0] hd, input logic [4:0] sc,
                           input logic [15:0] a1, input logic [15:0] a2,
                           input logic [15:0] a3);
        c_code = code; c_dev = dv; c_opts = op; c_long = lf; c_blk = bk;
        c_cyl = cy; c_head = hd; c_sec = sc; c_a1 = a1; c_a2 = a2; c_a3 = a3;
    endtask

    // issue the bench command; optionally poke a second start while busy
    task automatic issue(input bit poke, output int saw_err);
        int waited;
        @(negedge clk);
        cmd_code = c_code; dev_num = c_dev; cmd_opts = c_opts; long_form = c_long;
        blk_count = c_blk; cyl = c_cyl; head = c_head; sector = c_sec;
        arg1 = c_a1; arg2 = c_a2; arg3 = c_a3;
        nw = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(attn_req == 1'b1, "R2", "attn_req after start", attn_req, 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            cmd_code = ~c_code; dev_num = ~c_dev; arg1 = ~c_a1; blk_count = ~c_blk;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!done && waited < 40000) begin
            @(negedge clk);
            waited++;
        end
        chk(done == 1'b1, "R9", "done seen", done, 1);
        saw_err = err_code;
        @(negedge clk);
        chk(done == 1'b0, "R11", "done one cycle", done, 0);
    endtask

    task automatic check_words(input string req);
        chk(nw == exp_n(), req, "word count", nw, exp_n());
        for (int i = 0; i < 4; i++)
            if (i < exp_n() && i < nw)
                chk(got[i] == exp_word(i), req, $sformatf("word %0d", i), got[i], exp_word(i));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int e;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({busy, done, attn_req, cifr_we, err_code} == 6'd0, "R1", "reset outputs",
            {busy, done, attn_req, cifr_we, err_code}, 0);

        // R4 R5 read data
        set_cmd(5'd1, 3'd3, 6'h3f, 1'b0, 16'd8, 10'h2a5, 6'd13, 5'd17, 16'h1111, 16'h2222, 16'h3333);
        issue(1'b0, e);
        chk(e == 0, "R9", "read result", e, 0);
        check_words("R5");

        // R5 write data
        set_cmd(5'd2, 3'd7, 6'h00, 1'b1, 16'hffff, 10'h3ff, 6'd63, 5'd31, 16'h0, 16'h0, 16'h0);
        issue(1'b0, e);
        check_words("R5");

        // R6 generic two-word and four-word
        set_cmd(5'd8, 3'd1, 6'h2a, 1'b0, 16'd0, 10'd0, 6'd0, 5'd0, 16'hbeef, 16'h1234, 16'h5678);
        issue(1'b0, e);
        check_words("R6");
        chk(got[0][15:14] == 2'b00, "R4", "short type bits", got[0][15:14], 0);
        set_cmd(5'd9, 3'd5, 6'h15, 1'b1, 16'd0, 10'd0, 6'd0, 5'd0, 16'ha5a5, 16'h5a5a, 16'hc3c3);
        issue(1'b0, e);
        check_words("R6");

        // R3 attention failure, then R11 err held
        attn_ok_cfg = 1'b0;
        issue(1'b0, e);
        chk(e == 1, "R3", "attention error code", e, 1);
        chk(nw == 0, "R3", "no words after attention failure", nw, 0);
        repeat (5) @(negedge clk);
        chk(err_code == 2'd1, "R11", "err held", err_code, 1);
        attn_ok_cfg = 1'b1;

        // R2 start while busy ignored
        busy_cfg = 40;
        set_cmd(5'd1, 3'd2, 6'd0, 1'b0, 16'd5, 10'h12c, 6'd4, 5'd9, 16'd0, 16'd0, 16'd0);
        issue(1'b1, e);
        check_words("R2");
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R2", "no second command", busy, 0);
        busy_cfg = 3;

        // R8 boundary: drains after FULL_TRIES-1 set checks
        hold_cfg = 9999;
        set_cmd(5'd3, 3'd0, 6'd1, 1'b0, 16'd0, 10'd0, 6'd0, 5'd0, 16'h7777, 16'd0, 16'd0);
        issue(1'b0, e);
        chk(e == 0, "R7", "drain just below limit", e, 0);
        check_words("R7");
        hold_cfg = 1;

        // R8 never drains
        never_drain = 1'b1;
        issue(1'b0, e);
        chk(e == 2, "R8", "too slow code", e, 2);
        chk(nw == 1, "R8", "stopped after first word", nw, 1);
        never_drain = 1'b0;
        repeat (2) @(negedge clk);

        // R10 completion timeout
        busy_cfg = 1000;
        set_cmd(5'd2, 3'd1, 6'd0, 1'b0, 16'd2, 10'd7, 6'd1, 5'd2, 16'd0, 16'd0, 16'd0);
        issue(1'b0, e);
        chk(e == 3, "R10", "completion timeout code", e, 3);
        check_words("R10");
        busy_cfg = 3;
        repeat (1100) @(negedge clk);

        // random commands R4 R6 R9
        for (int n = 0; n < 40; n++) begin
            hold_cfg = $urandom_range(0, 4);
            busy_cfg = $urandom_range(0, 15);
            attn_lat = $urandom_range(0, 3);
            set_cmd(($urandom_range(0, 3) == 0) ? 5'($urandom_range(1, 2)) : 5'($urandom_range(0, 31)),
                    3'($urandom), 6'($urandom), 1'($urandom),
                    16'($urandom), 10'($urandom), 6'($urandom), 5'($urandom),
                    16'($urandom), 16'($urandom), 16'($urandom));
            issue(1'b0, e);
            chk(e == 0, "R9", "random result", e, 0);
            check_words("R4");
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule